// File: doc/BRIEF.md
# Card Configuration and Interrupt Controller

This block owns the option register through which a host configures a removable storage card, together with the reset sequencing and the shared ready/busy/interrupt pin that hang off it. The register holds a soft-reset bit, an interrupt-style bit and a six-bit mode index. Index zero selects the memory-style interface. Any other index selects I/O operation.

After power-on, after a hardware reset from the host pin, or while the soft-reset bit is set, the card is held in reset. It then runs a fixed-length internal initialisation, and the shared pin reads busy (low) for that whole time. Once the card is ready, the pin shows ready (high) in memory mode. In I/O mode the same pin becomes an active-low interrupt request. Requests from sources inside the card are shaped either into a fixed-width low pulse or into a low level that the card holds until it receives an acknowledge.

The host reset pin is active high. A pin that is held high from power-on does not keep the card in reset. Only a high level that follows a low level seen after power-on resets the card.

Top module: `card_cfg_irq_ctrl`

## Requirements
- R1: `cfg_rd_data_o` always shows the register: bit 7 soft reset, bit 6 level-interrupt select, bits 5:0 mode index. The value after power-on is 0x00.
- R2: Once set by a host write, the soft-reset bit stays 1 until a host write with bit 7 = 0 or a hardware reset clears it.
- R3: A write with bit 7 = 1 stores only bit 7. Bits 6:0 read back as 0 while soft reset is set, so the register reads 0x80.
- R4: A high level on `card_rst_i` that follows a low level seen after power-on clears the register to 0x00 and holds the card in reset for as long as the pin stays high. A pin held high continuously from power-on causes no reset beyond the power-on one.
- R5: `rdy_irq_n_o` is low while the card is held in reset (power-on, hardware pin or soft-reset bit). It stays low for a further INIT_CYCLES clocks after the hold ends, and only then may it go high.
- R6: With mode index 0 and the card not busy, `rdy_irq_n_o` is high and interrupt sources have no effect on it.
- R7: With a nonzero index and bit 6 = 0, a clock in which any bit of `irq_src_i` is high and no pulse is running drives `rdy_irq_n_o` low for exactly PULSE_W clocks, starting with the next cycle. Requests that arrive while a pulse runs are dropped.
- R8: With a nonzero index and bit 6 = 1, a request drives `rdy_irq_n_o` low from the next cycle. The line stays low until a cycle with `irq_clr_i` high and no request. A request in the same cycle as a clear wins.
- R9: Requests that arrive while the card is busy are discarded. Leaving I/O mode discards any pending level request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| card_rst_i | input | 1 | Host hardware reset pin, active high |
| cfg_wr_en_i | input | 1 | Host write strobe for the option register |
| cfg_wr_data_i | input | 8 | Host write data |
| irq_src_i | input | NSRC | Interrupt requests from sources inside the card |
| irq_clr_i | input | 1 | Acknowledge that clears a level interrupt |
| cfg_rd_data_o | output | 8 | Current register value |
| rdy_irq_n_o | output | 1 | Ready/busy in memory mode, active-low interrupt in I/O mode |

## Verification
The hardest situations to reach from the ports are a hardware reset that arrives while the soft-reset bit is set, and interrupt requests that arrive during initialisation.

To reach them, the stimulus first powers up with the reset pin already high, which must not reset the card. It then drops the pin and later raises it with the register at 0x80. Before the card is ready, it writes an I/O level-mode index and fires a request, which must then be lost.

Pulse mode is driven with a request held for many cycles, which exposes the one-cycle gap between back-to-back pulses. Level mode is driven with a request and a clear in the same cycle.

// File: rtl/card_cfg_pkg.sv
package card_cfg_pkg;

  localparam int IDX_W   = 6;
  localparam int REG_W   = 8;
  localparam int SRST_B  = 7;
  localparam int LVL_B   = 6;

  typedef struct packed {
    logic             srst;
    logic             lvl;
    logic [IDX_W-1:0] idx;
  } cfg_reg_t;

  localparam cfg_reg_t CFG_RESET = '0;

endpackage

// File: rtl/cfg_opt_reg.sv
module cfg_opt_reg
  import card_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             hw_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output cfg_reg_t         cfg
);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg <= CFG_RESET;
    end else if (hw_rst) begin
      cfg <= CFG_RESET;
    end else if (wr_en) begin
      cfg.srst <= wr_data[SRST_B];
      if (wr_data[SRST_B]) begin
        cfg.lvl <= 1'b0;
        cfg.idx <= '0;
      end else begin
        cfg.lvl <= wr_data[LVL_B];
        cfg.idx <= wr_data[IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/card_reset_seq.sv
module card_reset_seq #(
  parameter int INIT_CYCLES = 1024
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin,
  input  logic srst,
  output logic hw_rst,
  output logic busy
);

  localparam int CW = $clog2(INIT_CYCLES + 1);

  logic          pin_q;
  logic          armed;
  logic          hold;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pin_q <= 1'b1;
      armed <= 1'b0;
    end else begin
      pin_q <= rst_pin;
      if (!pin_q) armed <= 1'b1;
    end
  end

  assign hw_rst = armed & pin_q;
  assign hold   = hw_rst | srst;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt <= CW'(INIT_CYCLES);
    end else if (hold) begin
      cnt <= CW'(INIT_CYCLES);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign busy = hold | (cnt != '0);

endmodule

// File: rtl/irq_shaper.sv
module irq_shaper #(
  parameter int NSRC    = 4,
  parameter int PULSE_W = 4
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            en,
  input  logic            lvl,
  input  logic [NSRC-1:0] src,
  input  logic            clr,
  output logic            act
);

  localparam int PW = $clog2(PULSE_W + 1);

  logic          req;
  logic [PW-1:0] pcnt;
  logic          pend;

  assign req = |src;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pcnt <= '0;
      pend <= 1'b0;
    end else if (!en) begin
      pcnt <= '0;
      pend <= 1'b0;
    end else if (lvl) begin
      pcnt <= '0;
      if (req)      pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end else begin
      pend <= 1'b0;
      if (pcnt != '0) pcnt <= pcnt - PW'(1);
      else if (req)   pcnt <= PW'(PULSE_W);
    end
  end

  assign act = lvl ? pend : (pcnt != '0);

endmodule

// File: rtl/card_cfg_irq_ctrl.sv
module card_cfg_irq_ctrl
  import card_cfg_pkg::*;
#(
  parameter int INIT_CYCLES = 1024,
  parameter int PULSE_W     = 4,
  parameter int NSRC        = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             card_rst_i,
  input  logic             cfg_wr_en_i,
  input  logic [REG_W-1:0] cfg_wr_data_i,
  input  logic [NSRC-1:0]  irq_src_i,
  input  logic             irq_clr_i,
  output logic [REG_W-1:0] cfg_rd_data_o,
  output logic             rdy_irq_n_o
);

  cfg_reg_t cfg;
  logic     hw_rst;
  logic     busy;
  logic     io_mode;
  logic     irq_act;

  cfg_opt_reg u_reg (
    .clk     (clk),
    .por_n   (por_n),
    .hw_rst  (hw_rst),
    .wr_en   (cfg_wr_en_i),
    .wr_data (cfg_wr_data_i),
    .cfg     (cfg)
  );

  card_reset_seq #(.INIT_CYCLES(INIT_CYCLES)) u_seq (
    .clk     (clk),
    .por_n   (por_n),
    .rst_pin (card_rst_i),
    .srst    (cfg.srst),
    .hw_rst  (hw_rst),
    .busy    (busy)
  );

  assign io_mode = (cfg.idx != '0);

  irq_shaper #(.NSRC(NSRC), .PULSE_W(PULSE_W)) u_irq (
    .clk   (clk),
    .por_n (por_n),
    .en    (io_mode & ~busy),
    .lvl   (cfg.lvl),
    .src   (irq_src_i),
    .clr   (irq_clr_i),
    .act   (irq_act)
  );

  assign cfg_rd_data_o = cfg;

  always_comb begin
    if (busy)         rdy_irq_n_o = 1'b0;
    else if (io_mode) rdy_irq_n_o = ~irq_act;
    else              rdy_irq_n_o = 1'b1;
  end

endmodule

// File: rtl/card_cfg_irq_ctrl_chk.sv
module card_cfg_irq_ctrl_chk #(
  parameter int PULSE_W = 4
) (
  input logic       clk,
  input logic       por_n,
  input logic       card_rst_i,
  input logic       cfg_wr_en_i,
  input logic       irq_clr_i,
  input logic [7:0] cfg_rd_data_o,
  input logic       rdy_irq_n_o,
  input logic       hw_rst,
  input logic       busy
);

  AST_SRST_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_rd_data_o[7] && !cfg_wr_en_i && !hw_rst) |=> cfg_rd_data_o[7]); // R2

  AST_SRST_ONLY_BIT: assert property (@(posedge clk) disable iff (!por_n)
    cfg_rd_data_o[7] |-> (cfg_rd_data_o[6:0] == 7'd0)); // R3

  AST_HW_CLEARS_REG: assert property (@(posedge clk) disable iff (!por_n)
    hw_rst |=> (cfg_rd_data_o == 8'h00)); // R4

  AST_BUSY_PIN_LOW: assert property (@(posedge clk) disable iff (!por_n)
    busy |-> !rdy_irq_n_o); // R5

  AST_MEM_READY_HIGH: assert property (@(posedge clk) disable iff (!por_n)
    (!busy && cfg_rd_data_o[5:0] == 6'd0) |-> rdy_irq_n_o); // R6

  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    (!rdy_irq_n_o && !busy && cfg_rd_data_o[6] && cfg_rd_data_o[5:0] != 6'd0
     && !irq_clr_i && !cfg_wr_en_i && !card_rst_i) |=> !rdy_irq_n_o); // R8

  generate
    if (PULSE_W >= 2) begin : g_pulse_chk
      AST_PULSE_MIN_TWO: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(rdy_irq_n_o) && !busy && !cfg_rd_data_o[6] && cfg_rd_data_o[5:0] != 6'd0
         && !cfg_wr_en_i && !card_rst_i) |=> !rdy_irq_n_o); // R7
    end
  endgenerate

endmodule

bind card_cfg_irq_ctrl card_cfg_irq_ctrl_chk #(.PULSE_W(PULSE_W)) u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .card_rst_i    (card_rst_i),
  .cfg_wr_en_i   (cfg_wr_en_i),
  .irq_clr_i     (irq_clr_i),
  .cfg_rd_data_o (cfg_rd_data_o),
  .rdy_irq_n_o   (rdy_irq_n_o),
  .hw_rst        (hw_rst),
  .busy          (busy)
);

// File: tb/card_cfg_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module card_cfg_irq_ctrl_tb_top;

  localparam int INIT = 12;
  localparam int PW   = 3;
  localparam int NS   = 4;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          card_rst_i = 1'b1;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = 8'h00;
  logic [NS-1:0] src = '0;
  logic          clr = 1'b0;
  logic [7:0]    rd_data;
  logic          pin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  card_cfg_irq_ctrl #(.INIT_CYCLES(INIT), .PULSE_W(PW), .NSRC(NS)) dut_i (
    .clk           (clk),
    .por_n         (por_n),
    .card_rst_i    (card_rst_i),
    .cfg_wr_en_i   (wr_en),
    .cfg_wr_data_i (wr_data),
    .irq_src_i     (src),
    .irq_clr_i     (clr),
    .cfg_rd_data_o (rd_data),
    .rdy_irq_n_o   (pin)
  );

  // behavioural reference model, state advanced on every rising edge
  int m_pinq, m_armed, m_srst, m_lvl, m_idx, m_cnt, m_pcnt, m_pend;
  int t_hw, t_hold, t_busy, t_en, t_req;

  function automatic int model_busy();
    return ((m_armed != 0 && m_pinq != 0) || m_srst != 0 || m_cnt > 0) ? 1 : 0;
  endfunction

  function automatic int model_pin();
    if (model_busy() != 0) return 0;
    if (m_idx == 0) return 1;
    if (m_lvl != 0) return (m_pend != 0) ? 0 : 1;
    return (m_pcnt > 0) ? 0 : 1;
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_pinq = 1; m_armed = 0; m_srst = 0; m_lvl = 0; m_idx = 0;
      m_cnt = INIT; m_pcnt = 0; m_pend = 0;
    end else begin
      t_hw   = (m_armed != 0 && m_pinq != 0) ? 1 : 0;
      t_hold = (t_hw != 0 || m_srst != 0) ? 1 : 0;
      t_busy = model_busy();
      t_en   = (m_idx != 0 && t_busy == 0) ? 1 : 0;
      t_req  = (src != '0) ? 1 : 0;
      // interrupt shaping uses the mode fields before this edge's write
      if (t_en == 0) begin
        m_pcnt = 0; m_pend = 0;
      end else if (m_lvl != 0) begin
        m_pcnt = 0;
        if (t_req != 0) m_pend = 1;
        else if (clr) m_pend = 0;
      end else begin
        m_pend = 0;
        if (m_pcnt > 0) m_pcnt = m_pcnt - 1;
        else if (t_req != 0) m_pcnt = PW;
      end
      if (t_hold != 0) m_cnt = INIT;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (t_hw != 0) begin
        m_srst = 0; m_lvl = 0; m_idx = 0;
      end else if (wr_en) begin
        m_srst = wr_data[7];
        m_lvl  = wr_data[7] ? 0 : int'(wr_data[6]);
        m_idx  = wr_data[7] ? 0 : int'(wr_data[5:0]);
      end
      if (m_pinq == 0) m_armed = 1;
      m_pinq = int'(card_rst_i);
    end
  end

  function automatic int model_reg();
    return (m_srst << 7) | (m_lvl << 6) | m_idx;
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (por_n && !done) begin
      checks++;
      if (int'(rd_data) != model_reg()) begin
        errors++;
        $display("FAIL R1 register: actual %02h expected %02h at %0t", rd_data, model_reg(), $time);
      end
      checks++;
      if (int'(pin) != model_pin()) begin
        errors++;
        if (model_busy() != 0)
          $display("FAIL R5 pin: actual %0d expected %0d at %0t", pin, model_pin(), $time);
        else if (m_idx == 0)
          $display("FAIL R6 pin: actual %0d expected %0d at %0t", pin, model_pin(), $time);
        else if (m_lvl != 0)
          $display("FAIL R8 pin: actual %0d expected %0d at %0t", pin, model_pin(), $time);
        else
          $display("FAIL R7 pin: actual %0d expected %0d at %0t", pin, model_pin(), $time);
      end
    end
  end

  task automatic expect_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic fire(input logic [NS-1:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
    src = '0;
  endtask

  initial begin
    // R4: pin high from power-on, only the power-on initialisation
    cyc(4);
    por_n = 1'b1;
    @(negedge clk);
    expect_val("R5 busy after power-on", int'(pin), 0);
    expect_val("R1 reset value", int'(rd_data), 8'h00);
    cyc(INIT + 3);
    expect_val("R4 pin high since power-on gives no reset", int'(pin), 1);
    expect_val("R6 memory mode ready", int'(pin), 1);

    // R4: low then high resets
    card_rst_i = 1'b0;
    cyc(3);
    write_reg(8'h05);
    expect_val("R1 index readback", int'(rd_data), 8'h05);
    card_rst_i = 1'b1;
    cyc(3);
    expect_val("R4 hw reset clears register", int'(rd_data), 8'h00);
    expect_val("R4 hw reset holds busy", int'(pin), 0);
    cyc(5);
    card_rst_i = 1'b0;
    cyc(INIT / 2);
    expect_val("R5 still initialising", int'(pin), 0);
    cyc(INIT);
    expect_val("R5 ready after init", int'(pin), 1);

    // R8: level mode
    write_reg(8'h45);
    expect_val("R1 level and index readback", int'(rd_data), 8'h45);
    fire(4'b0100);
    expect_val("R8 level asserted", int'(pin), 0);
    cyc(6);
    expect_val("R8 level held without clear", int'(pin), 0);
    @(negedge clk); clr = 1'b1; src = 4'b0001;
    @(negedge clk); src = '0;
    expect_val("R8 request wins over clear", int'(pin), 0);
    @(negedge clk); clr = 1'b0;
    expect_val("R8 clear releases line", int'(pin), 1);

    // R7: pulse mode
    write_reg(8'h03);
    fire(4'b1000);
    expect_val("R7 pulse low", int'(pin), 0);
    cyc(PW);
    expect_val("R7 pulse ended", int'(pin), 1);
    @(negedge clk); src = 4'b0010;
    cyc(3 * PW + 4);
    src = '0;
    cyc(PW + 2);
    expect_val("R7 line idle after held request", int'(pin), 1);

    // R6: memory mode ignores sources
    write_reg(8'h00);
    fire(4'b1111);
    expect_val("R6 source ignored in memory mode", int'(pin), 1);

    // R2 / R3: soft reset
    write_reg(8'h83);
    expect_val("R3 soft reset stores only bit 7", int'(rd_data), 8'h80);
    expect_val("R5 soft reset busy", int'(pin), 0);
    cyc(3 * INIT);
    expect_val("R2 soft reset sticks", int'(rd_data), 8'h80);
    expect_val("R5 held while soft reset set", int'(pin), 0);
    write_reg(8'hC5);
    expect_val("R3 write with bit 7 set keeps low bits zero", int'(rd_data), 8'h80);
    write_reg(8'h00);
    expect_val("R2 host write 0 clears", int'(rd_data), 8'h00);
    cyc(INIT + 2);
    expect_val("R5 ready after soft reset", int'(pin), 1);

    // R4 with soft reset set
    write_reg(8'h80);
    card_rst_i = 1'b1;
    cyc(3);
    expect_val("R4 hw reset clears soft reset bit", int'(rd_data), 8'h00);
    card_rst_i = 1'b0;

    // R9: requests during busy are lost
    cyc(2);
    write_reg(8'h41);
    fire(4'b0001);
    cyc(INIT + 2);
    expect_val("R9 request while busy discarded", int'(pin), 1);
    fire(4'b0001);
    expect_val("R8 level after ready", int'(pin), 0);
    write_reg(8'h40);
    write_reg(8'h41);
    expect_val("R9 pending dropped on leaving I/O mode", int'(pin), 1);

    cyc(4);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule